// File: doc/BRIEF.md
# Compare-Match Timer with Shared Start Register

A multi-channel interval timer that sits behind a single-cycle register bus. Every channel owns an up-counter, a compare register and a control/status register. One start register, common to all channels, carries a run bit per channel. Setting a bit lets that channel count; clearing it freezes the counter where it stands. Each channel also has a clock prescaler, which emits one count-enable pulse every D clock cycles while the channel runs. D comes from a select field in the channel's control word.

When a count pulse finds the counter equal to the compare value, the counter returns to zero instead of incrementing and the channel's match flag is set. This gives periodic operation with period (compare+1)·D cycles. An interrupt line per channel follows the match flag while the channel's interrupt enable is set. The flag is cleared by writing 0 to its bit. Writing 1 to it changes nothing, so a read-modify-write of the control word cannot lose a flag.

A parameter CNT_W selects the 16-bit or the 32-bit variant. The variant sets the register stride, the control-word layout, the divider table and whether a second (overrun) flag exists.

Top module: `match_timer`

## Requirements
- R1: After reset every counter is 0, every compare register holds all ones, every control word reads 0, the start register reads 0 and all interrupt lines are low.
- R2: Bit i of the start register (byte offset 0) runs channel i when 1 and freezes its counter and prescaler when 0. Writing the start register never disturbs the counters of other channels.
- R3: With stride S = CNT_W/8, channel i has its control word at (i+1)·4·S, its counter at (i+1)·4·S+S and its compare register at (i+1)·4·S+2·S. Counter and compare are CNT_W wide. The control word and start register are 16-bit fields, zero-extended on read in the 32-bit variant.
- R4: The divider is D = 8·4^sel with sel = control bits [1:0] in the 16-bit variant. In the 32-bit variant, sel = control bits [2:0], and D = 1 for sel 0 or 2^(sel-1) otherwise (0x01a4 gives D = 8). A running channel advances its counter once every D clocks, the first advance landing D clocks after the start write.
- R5: The prescaler restarts from zero whenever the channel's run bit is 0, so partial prescaler progress is discarded on stop.
- R6: A count pulse that finds counter == compare loads 0 into the counter and sets the match flag. The match flag is bit 7 in the 16-bit variant and bit 15 in the 32-bit variant.
- R7: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R8: In the 32-bit variant, bit 14 is an overrun flag set by a match while the match flag is already set. It clears on a write of 0 to bit 14, independently of bit 15.
- R9: A channel's interrupt line is high exactly while its match flag and its interrupt-enable bit are both set. The enable is bit 6 in the 16-bit variant and bit 5 in the 32-bit variant.
- R10: Counter and compare writes are accepted at any time, also while the channel runs. A counter write takes precedence over a count pulse in the same cycle, and counting continues from the written value.
- R11: Read data appears on rdData one clock after rdEn, and reading any register has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data, registered |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
Every register write takes effect on the clock edge that samples it. Read data is due one edge after rdEn. A channel started at edge E0 makes its k-th count at edge E(k·D), and a stopping write still counts on its own edge. The bench gives every write and read exactly one edge and every idle step one edge, and it places the start and stop writes so that the number of running edges, and from it the expected counter value, is known exactly. Interrupt lines are sampled between edges, only while all channels are stopped.

// File: rtl/mt_pkg.sv
package mt_pkg;
  // write strobes sent from the register decoder to one channel
  typedef struct packed {
    logic wrCtrl;
    logic wrCnt;
    logic wrCmp;
  } chStb_t;
endpackage

// File: rtl/mt_channel.sv
module mt_channel
  import mt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  chStb_t           stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [15:0]      ctrlRd,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cmpQ,
  output logic             flagQ,
  output logic             irq
);
  localparam bit IS32     = (CNT_W == 32);
  localparam int CTRL_W   = IS32 ? 16 : 8;
  localparam int SEL_W    = IS32 ? 3 : 2;
  localparam int FLAG_BIT = IS32 ? 15 : 7;
  localparam int IE_BIT   = IS32 ? 5 : 6;
  localparam int OVR_BIT  = 14;
  localparam int PRE_W    = 10;
  localparam logic [15:0] FMASK = IS32 ? 16'hC000 : 16'h0080;

  logic [CTRL_W-1:0] ctrlQ;
  logic [PRE_W-1:0]  preQ;
  logic              ovrQ;
  logic              tick;
  logic              hit;
  logic [SEL_W-1:0]  sel;

  function automatic logic [PRE_W-1:0] divM1(input logic [SEL_W-1:0] s);
    int d;
    if (IS32) d = (s == '0) ? 1 : (1 << (int'(s) - 1));
    else      d = 8 << (2 * int'(s));
    return PRE_W'(d - 1);
  endfunction

  assign sel  = ctrlQ[SEL_W-1:0];
  assign tick = run && (preQ >= divM1(sel));
  assign hit  = tick && !stb.wrCnt && (cntQ == cmpQ);

  // prescaler: free while running, held at zero while stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preQ <= '0;
    else if (!run) preQ <= '0;
    else if (tick) preQ <= '0;
    else           preQ <= preQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      cmpQ <= '1;
    end else begin
      if (stb.wrCnt)  cntQ <= wrData;
      else if (tick)  cntQ <= (cntQ == cmpQ) ? '0 : cntQ + 1'b1;
      if (stb.wrCmp)  cmpQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= wrData[CTRL_W-1:0] & ~FMASK[CTRL_W-1:0];
      if (hit)                                flagQ <= 1'b1;
      else if (stb.wrCtrl && !wrData[FLAG_BIT]) flagQ <= 1'b0;
    end
  end

  generate
    if (IS32) begin : g_ovr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               ovrQ <= 1'b0;
        else if (hit && flagQ)                   ovrQ <= 1'b1;
        else if (stb.wrCtrl && !wrData[OVR_BIT]) ovrQ <= 1'b0;
      end
    end else begin : g_noOvr
      assign ovrQ = 1'b0;
    end
  endgenerate

  assign ctrlRd = 16'(ctrlQ) | (16'(flagQ) << FLAG_BIT) | (16'(ovrQ) << OVR_BIT);
  assign irq    = flagQ & ctrlQ[IE_BIT];
endmodule

// File: rtl/mt_dp.sv
module mt_dp
  import mt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0]            runVec,
  input  chStb_t [NUM_CH-1:0]          stbVec,
  input  logic [CNT_W-1:0]             wrData,
  output logic [NUM_CH-1:0][15:0]      ctrlRd,
  output logic [NUM_CH-1:0][CNT_W-1:0] cntVec,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmpVec,
  output logic [NUM_CH-1:0]            flagVec,
  output logic [NUM_CH-1:0]            irq
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mt_channel #(.CNT_W(CNT_W)) u_ch (
        .clk    (clk),
        .rstN   (rstN),
        .run    (runVec[c]),
        .stb    (stbVec[c]),
        .wrData (wrData),
        .ctrlRd (ctrlRd[c]),
        .cntQ   (cntVec[c]),
        .cmpQ   (cmpVec[c]),
        .flagQ  (flagVec[c]),
        .irq    (irq[c])
      );
    end
  endgenerate
endmodule

// File: rtl/mt_ctl.sv
module mt_ctl
  import mt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_CH-1:0]            startIn,
  input  logic [NUM_CH-1:0][15:0]      ctrlRd,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cntVec,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmpVec,
  output logic [NUM_CH-1:0]            runVec,
  output chStb_t [NUM_CH-1:0]          stbVec,
  output logic [CNT_W-1:0]             rdData
);
  localparam int STRIDE    = CNT_W / 8;
  localparam int PITCH     = 4 * STRIDE;
  localparam int STRIDE_LG = $clog2(STRIDE);
  localparam int PITCH_LG  = $clog2(PITCH);
  localparam int SLOT_W    = ADDR_W - PITCH_LG;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        idx;
  logic              aligned;
  logic              startSel;
  logic [CNT_W-1:0]  rdNext;

  assign slot     = addr[ADDR_W-1:PITCH_LG];
  assign idx      = addr[PITCH_LG-1:STRIDE_LG];
  assign aligned  = (addr[STRIDE_LG-1:0] == '0);
  assign startSel = (addr == '0);

  always_comb begin
    stbVec = '0;
    rdNext = '0;
    if (startSel) rdNext = CNT_W'(runVec);
    for (int c = 0; c < NUM_CH; c++) begin
      if (aligned && slot == SLOT_W'(c + 1)) begin
        case (idx)
          2'd0: begin stbVec[c].wrCtrl = wrEn; rdNext = CNT_W'(ctrlRd[c]); end
          2'd1: begin stbVec[c].wrCnt  = wrEn; rdNext = cntVec[c]; end
          2'd2: begin stbVec[c].wrCmp  = wrEn; rdNext = cmpVec[c]; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runVec <= '0;
      rdData <= '0;
    end else begin
      if (wrEn && startSel) runVec <= startIn;
      if (rdEn)             rdData <= rdNext;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0]            runVec;
  chStb_t [NUM_CH-1:0]          stbVec;
  logic [NUM_CH-1:0][15:0]      ctrlRd;
  logic [NUM_CH-1:0][CNT_W-1:0] cntVec;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpVec;
  logic [NUM_CH-1:0]            flagVec;

  mt_ctl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .startIn (wrData[NUM_CH-1:0]),
    .ctrlRd  (ctrlRd),
    .cntVec  (cntVec),
    .cmpVec  (cmpVec),
    .runVec  (runVec),
    .stbVec  (stbVec),
    .rdData  (rdData)
  );

  mt_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .runVec  (runVec),
    .stbVec  (stbVec),
    .wrData  (wrData),
    .ctrlRd  (ctrlRd),
    .cntVec  (cntVec),
    .cmpVec  (cmpVec),
    .flagVec (flagVec),
    .irq     (irq)
  );
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         wrEn,
  input logic [NUM_CH-1:0]            runVec,
  input logic [NUM_CH-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_CH-1:0]            flagVec,
  input logic [NUM_CH-1:0]            irq
);
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (!runVec[i] && !wrEn) |=> $stable(cntVec[i])); // R2

      AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
        !wrEn |=> ((cntVec[i] == $past(cntVec[i])) ||
                   (cntVec[i] == CNT_W'($past(cntVec[i]) + 1'b1)) ||
                   (cntVec[i] == '0))); // R4

      AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        ((cntVec[i] != '0) && !wrEn) |=> ((cntVec[i] != '0) || flagVec[i])); // R6

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (flagVec[i] && !wrEn) |=> flagVec[i]); // R7

      AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
        (irq[i] && !wrEn) |=> irq[i]); // R9
    end
  endgenerate
endmodule

bind match_timer mt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .runVec  (runVec),
  .cntVec  (cntVec),
  .flagVec (flagVec),
  .irq     (irq)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OID = 2'd2, OIQ = 2'd3;

  typedef struct packed {
    logic        inst;
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 80;
  // u0: 16-bit, start 0, ch0 8/10/12, ch1 16/18/20; u1: 32-bit, ch0 16/20/24
  localparam vec_t VECS [NV] = '{
    '{1'b0, OW,  8'd12, 32'h3,    4'd0},   // cmp0 = 3
    '{1'b0, OW,  8'd8,  32'h40,   4'd0},   // ie, divide by 8
    '{1'b0, OW,  8'd0,  32'h1,    4'd0},   // start ch0 (E0)
    '{1'b0, OID, 8'd0,  32'd47,   4'd0},
    '{1'b0, OW,  8'd0,  32'h0,    4'd0},   // stop at E48: 6 counts
    '{1'b0, ORD, 8'd10, 32'h2,    4'd6},   // R6 wrap after 3
    '{1'b0, ORD, 8'd8,  32'hC0,   4'd6},   // R6 flag bit 7
    '{1'b0, OIQ, 8'd0,  32'h1,    4'd9},   // R9
    '{1'b0, OW,  8'd8,  32'hC0,   4'd0},   // writing 1 to flag
    '{1'b0, ORD, 8'd8,  32'hC0,   4'd7},   // R7 unchanged
    '{1'b0, OW,  8'd8,  32'h80,   4'd0},   // ie off, flag kept
    '{1'b0, OIQ, 8'd0,  32'h0,    4'd9},   // R9 gated by enable
    '{1'b0, ORD, 8'd8,  32'h80,   4'd7},   // R7
    '{1'b0, OW,  8'd8,  32'h40,   4'd0},   // clear flag
    '{1'b0, ORD, 8'd8,  32'h40,   4'd7},   // R7 cleared
    '{1'b0, OIQ, 8'd0,  32'h0,    4'd9},   // R9
    '{1'b0, OW,  8'd0,  32'h2,    4'd0},   // start ch1 only (E0)
    '{1'b0, ORD, 8'd0,  32'h2,    4'd2},   // R2 start readback (E1)
    '{1'b0, OID, 8'd0,  32'd14,   4'd0},
    '{1'b0, OW,  8'd0,  32'h0,    4'd0},   // stop at E16
    '{1'b0, ORD, 8'd18, 32'h2,    4'd2},   // R2 ch1 counted 2
    '{1'b0, ORD, 8'd10, 32'h2,    4'd2},   // R2 ch0 held
    '{1'b0, ORD, 8'd18, 32'h2,    4'd11},  // R11 repeat read same
    '{1'b0, OW,  8'd18, 32'h0,    4'd0},
    '{1'b0, OW,  8'd0,  32'h2,    4'd0},
    '{1'b0, OID, 8'd0,  32'd4,    4'd0},
    '{1'b0, OW,  8'd0,  32'h0,    4'd0},   // 5 running edges
    '{1'b0, OW,  8'd0,  32'h2,    4'd0},
    '{1'b0, OID, 8'd0,  32'd3,    4'd0},
    '{1'b0, OW,  8'd0,  32'h0,    4'd0},   // 4 running edges
    '{1'b0, ORD, 8'd18, 32'h0,    4'd5},   // R5 prescaler restarted
    '{1'b0, OW,  8'd16, 32'h3,    4'd0},   // divide by 512
    '{1'b0, OW,  8'd0,  32'h2,    4'd0},
    '{1'b0, OID, 8'd0,  32'd511,  4'd0},
    '{1'b0, OW,  8'd0,  32'h0,    4'd0},   // 512 edges
    '{1'b0, ORD, 8'd18, 32'h1,    4'd4},   // R4 one count
    '{1'b0, OW,  8'd16, 32'h0,    4'd0},   // divide by 8
    '{1'b0, OW,  8'd0,  32'h2,    4'd0},   // E0
    '{1'b0, OID, 8'd0,  32'd9,    4'd0},   // count at E8
    '{1'b0, OW,  8'd18, 32'h100,  4'd0},   // write counter E10
    '{1'b0, OID, 8'd0,  32'd5,    4'd0},
    '{1'b0, OW,  8'd0,  32'h0,    4'd0},   // count at E16
    '{1'b0, ORD, 8'd18, 32'h101,  4'd10},  // R10
    '{1'b0, OW,  8'd0,  32'h2,    4'd0},   // E0
    '{1'b0, OID, 8'd0,  32'd3,    4'd0},
    '{1'b0, OW,  8'd20, 32'h102,  4'd0},   // compare write at E4
    '{1'b0, OID, 8'd0,  32'd11,   4'd0},
    '{1'b0, OW,  8'd0,  32'h0,    4'd0},   // E16
    '{1'b0, ORD, 8'd18, 32'h0,    4'd10},  // R10 matched new compare
    '{1'b0, ORD, 8'd16, 32'h80,   4'd6},   // R6
    '{1'b0, OW,  8'd10, 32'h0,    4'd0},
    '{1'b0, OW,  8'd12, 32'h0,    4'd0},   // cmp0 = 0
    '{1'b0, OW,  8'd0,  32'h1,    4'd0},   // E0
    '{1'b0, OID, 8'd0,  32'd7,    4'd0},
    '{1'b0, OW,  8'd8,  32'h40,   4'd0},   // clear at match edge E8
    '{1'b0, OW,  8'd0,  32'h0,    4'd0},
    '{1'b0, ORD, 8'd8,  32'hC0,   4'd7},   // R7 set wins
    '{1'b0, OIQ, 8'd0,  32'h1,    4'd9},   // R9 ch1 not enabled
    '{1'b1, OW,  8'd20, 32'h12345678, 4'd0},
    '{1'b1, ORD, 8'd20, 32'h12345678, 4'd3},  // R3 full width
    '{1'b1, ORD, 8'd24, 32'hFFFFFFFF, 4'd3},  // R3 compare offset
    '{1'b1, OW,  8'd20, 32'h0,    4'd0},
    '{1'b1, OW,  8'd16, 32'h1A4,  4'd0},   // divide by 8
    '{1'b1, OW,  8'd0,  32'h1,    4'd0},
    '{1'b1, OID, 8'd0,  32'd15,   4'd0},
    '{1'b1, OW,  8'd0,  32'h0,    4'd0},   // 16 edges
    '{1'b1, ORD, 8'd20, 32'h2,    4'd4},   // R4
    '{1'b1, ORD, 8'd16, 32'h1A4,  4'd3},   // R3
    '{1'b1, OW,  8'd24, 32'h0,    4'd0},
    '{1'b1, OW,  8'd16, 32'h20,   4'd0},   // ie, divide by 1
    '{1'b1, OW,  8'd20, 32'h0,    4'd0},
    '{1'b1, OW,  8'd0,  32'h1,    4'd0},
    '{1'b1, OID, 8'd0,  32'd1,    4'd0},
    '{1'b1, OW,  8'd0,  32'h0,    4'd0},   // two matches
    '{1'b1, ORD, 8'd16, 32'hC020, 4'd8},   // R8 overrun
    '{1'b1, OIQ, 8'd0,  32'h1,    4'd9},   // R9
    '{1'b1, OW,  8'd16, 32'h8020, 4'd0},
    '{1'b1, ORD, 8'd16, 32'h8020, 4'd8},   // R8 bit 14 alone
    '{1'b1, OW,  8'd16, 32'h20,   4'd0},
    '{1'b1, ORD, 8'd16, 32'h20,   4'd8}    // R8
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, instSel = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [15:0] rd0;
  logic [31:0] rd1;
  logic [1:0]  irq0, irq1;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  match_timer #(.NUM_CH(2), .CNT_W(16), .ADDR_W(8)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn & ~instSel), .rdEn(rdEn & ~instSel),
    .addr(addr), .wrData(wrData[15:0]), .rdData(rd0), .irq(irq0));

  match_timer #(.NUM_CH(2), .CNT_W(32), .ADDR_W(8)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn & instSel), .rdEn(rdEn & instSel),
    .addr(addr), .wrData(wrData), .rdData(rd1), .irq(irq1));

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWr(input logic inst, input logic [7:0] a, input logic [31:0] d);
    instSel = inst; addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRd(input logic inst, input logic [7:0] a, output logic [31:0] v);
    instSel = inst; addr = a; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    v = inst ? rd1 : {16'h0, rd0};
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    doRd(1'b0, 8'd8, v);  check(1, v, 32'h0);
    doRd(1'b0, 8'd10, v); check(1, v, 32'h0);
    doRd(1'b0, 8'd12, v); check(1, v, 32'hFFFF);
    doRd(1'b0, 8'd0, v);  check(1, v, 32'h0);
    doRd(1'b1, 8'd32, v); check(1, v, 32'h0);
    check(1, {30'h0, irq0}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        OW:  doWr(VECS[k].inst, VECS[k].addr, VECS[k].data);
        ORD: begin
          doRd(VECS[k].inst, VECS[k].addr, v);
          check(int'(VECS[k].req), v, VECS[k].data);
        end
        OID: repeat (int'(VECS[k].data)) @(negedge clk);
        default: check(int'(VECS[k].req),
                       {30'h0, (VECS[k].inst ? irq1 : irq0)}, VECS[k].data);
      endcase
    end

    // R1 reset in the middle of a run
    doWr(1'b0, 8'd0, 32'h1);
    repeat (20) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, {30'h0, irq0}, 32'h0);
    doRd(1'b0, 8'd10, v); check(1, v, 32'h0);
    doRd(1'b0, 8'd8, v);  check(1, v, 32'h0);
    doRd(1'b0, 8'd12, v); check(1, v, 32'hFFFF);
    doRd(1'b0, 8'd0, v);  check(1, v, 32'h0);
    doRd(1'b1, 8'd16, v); check(1, v, 32'h0);
    finishRun();
  end
endmodule